// File: doc/BRIEF.md
# Stepped Dial Position Sequencer

This block moves a moving-coil meter needle one equal step each second. A digital rheostat with a 10-bit wiper sets the gain of an amplifier that drives the meter. The block supplies the rheostat's two control inputs: an increment strobe and a return-to-zero reload. Each second-tick from the timebase opens a timing window. The window is resynchronized into the fast oscillator domain. While it is open, a counted gate lets a fixed number of single-cycle increment strobes through (17 by default), so 60 ticks sweep the wiper close to full scale.

Accepted ticks are counted in a seconds counter. Every 60th accepted tick produces a one-cycle reload that returns the wiper to zero. The increment strobes pass through a short delay line, so the reload is always applied before the first strobe of the same tick. A mirror of the wiper position is kept inside the block and brought out so that the dial value can be observed. The mirror follows the strobes and reloads and stops at full scale. A tick that arrives while a burst is still in progress is discarded.

Top module: `dial_step_seq`

## Requirements
- R1: A synchronous active-high reset drives `pos_o` to 0, holds `inc_o` and `reload_o` low, and restarts the seconds count at zero.
- R2: Each accepted tick produces exactly STEP increment strobes (17 by default). Each strobe is high for one clock cycle and is followed by at least one low cycle.
- R3: The burst length is set by counting strobes, not by the window duration. The gate closes after the STEP-th strobe even though the default 40-cycle window has room for 20.
- R4: With default parameters, if `tick_i` is first sampled high at clock edge k, the first increment strobe of that burst is high in the cycle after edge k+8.
- R5: Counting accepted ticks from reset, the 60th, 120th and so on each raise `reload_o` for exactly one cycle, in the cycle after edge k+2. `pos_o` is 0 in the following cycle.
- R6: A reload always precedes the first increment strobe of the same tick by at least DELAY_STAGES cycles.
- R7: A rising `tick_i` seen while a window is open or a burst is in progress is ignored. It produces no strobes, no reload and no advance of the seconds count.
- R8: `pos_o` saturates at 1023 and never wraps, even when more strobes arrive.
- R9: `pos_o` rises by exactly one for each increment strobe, becomes 0 after a reload, and is otherwise stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-second tick from the timebase, asynchronous level |
| inc_o | output | 1 | Registered increment strobe to the rheostat |
| reload_o | output | 1 | Registered one-cycle return-to-zero to the rheostat |
| pos_o | output | POS_BITS | Mirrored wiper position |

## Verification
The hardest case to reach is a tick that rises while an earlier burst is still in progress. Producing it takes a second rising edge within about forty fast cycles of an accepted one, which ordinary one-second spacing never does. The stimulus therefore inserts a second tick pulse 8 to 20 cycles after some accepted ticks, and checks that the strobe count and the minute reload are unaffected. Saturation cannot be reached with 17 steps per tick, so a second instance with 20 steps per tick runs on the same stimulus and drives its wiper into the full-scale limit.

// File: rtl/dial_seq_pkg.sv
package dial_seq_pkg;

  // Gate sequencer states: a strobe is emitted in GATE_HIGH only
  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_HIGH = 2'd1,
    GATE_LOW  = 2'd2,
    GATE_DONE = 2'd3
  } gate_state_t;

endpackage

// File: rtl/dial_tick_window.sv
module dial_tick_window #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_CYCLES  = 40,
  parameter int MIN_TICKS   = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic gate_busy_i,
  output logic win_o,
  output logic reload_o
);
  localparam int WIN_W = $clog2(WIN_CYCLES + 1);
  localparam int SEC_W = $clog2(MIN_TICKS);

  // Synchronizer plus one extra stage for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic [WIN_W-1:0]     win_cnt_q;
  logic [SEC_W-1:0]     sec_q;
  logic                 reload_q;
  logic                 rise;
  logic                 accept;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], tick_i};
  end

  assign rise   = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign accept = rise & (win_cnt_q == '0) & ~gate_busy_i;

  // Window timer: open for WIN_CYCLES cycles after an accepted tick
  always_ff @(posedge clk) begin
    if (rst)                   win_cnt_q <= '0;
    else if (accept)           win_cnt_q <= WIN_W'(WIN_CYCLES);
    else if (win_cnt_q != '0)  win_cnt_q <= win_cnt_q - 1'b1;
  end

  // Seconds count and minute reload
  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q    <= '0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= 1'b0;
      if (accept) begin
        if (sec_q == SEC_W'(MIN_TICKS - 1)) begin
          sec_q    <= '0;
          reload_q <= 1'b1;
        end else begin
          sec_q <= sec_q + 1'b1;
        end
      end
    end
  end

  assign win_o    = (win_cnt_q != '0);
  assign reload_o = reload_q;

endmodule

// File: rtl/dial_burst_gate.sv
module dial_burst_gate
  import dial_seq_pkg::*;
#(
  parameter int STEP         = 17,
  parameter int DELAY_STAGES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic win_i,
  output logic busy_o,
  output logic inc_o
);
  localparam int CNT_W = $clog2(STEP + 1);

  logic        win_sync_q;
  gate_state_t state_q;
  logic [CNT_W-1:0] sent_q;
  logic        pulse;

  // Resynchronize the window to the oscillator clock
  always_ff @(posedge clk) begin
    if (rst) win_sync_q <= 1'b0;
    else     win_sync_q <= win_i;
  end

  // Counted gate: alternate high/low while the window is open, stop at STEP
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_IDLE;
      sent_q  <= '0;
    end else begin
      case (state_q)
        GATE_IDLE: if (win_sync_q) begin
          state_q <= GATE_HIGH;
          sent_q  <= CNT_W'(1);
        end
        GATE_HIGH: state_q <= (sent_q == CNT_W'(STEP)) ? GATE_DONE : GATE_LOW;
        GATE_LOW: begin
          if (win_sync_q) begin
            state_q <= GATE_HIGH;
            sent_q  <= sent_q + 1'b1;
          end else begin
            state_q <= GATE_DONE;
          end
        end
        default: if (!win_sync_q) begin
          state_q <= GATE_IDLE;
          sent_q  <= '0;
        end
      endcase
    end
  end

  assign pulse  = (state_q == GATE_HIGH);
  assign busy_o = (state_q != GATE_IDLE);

  // Delay line so a reload of the same tick lands first
  generate
    if (DELAY_STAGES == 0) begin : g_nodly
      assign inc_o = pulse;
    end else if (DELAY_STAGES == 1) begin : g_dly1
      logic dly_q;
      always_ff @(posedge clk) begin
        if (rst) dly_q <= 1'b0;
        else     dly_q <= pulse;
      end
      assign inc_o = dly_q;
    end else begin : g_dlyn
      logic [DELAY_STAGES-1:0] dly_q;
      always_ff @(posedge clk) begin
        if (rst) dly_q <= '0;
        else     dly_q <= {dly_q[DELAY_STAGES-2:0], pulse};
      end
      assign inc_o = dly_q[DELAY_STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dial_pos_mirror.sv
module dial_pos_mirror #(
  parameter int POS_BITS = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reload_i,
  input  logic                inc_i,
  output logic [POS_BITS-1:0] pos_o
);
  localparam logic [POS_BITS-1:0] POS_MAX = '1;

  logic [POS_BITS-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (rst)                            pos_q <= '0;
    else if (reload_i)                  pos_q <= '0;
    else if (inc_i && pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/dial_step_seq.sv
module dial_step_seq #(
  parameter int POS_BITS     = 10,
  parameter int STEP         = 17,
  parameter int MIN_TICKS    = 60,
  parameter int WIN_CYCLES   = 40,
  parameter int DELAY_STAGES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_i,
  output logic                inc_o,
  output logic                reload_o,
  output logic [POS_BITS-1:0] pos_o
);
  logic win;
  logic gate_busy;
  logic inc_int;
  logic reload_int;

  dial_tick_window #(
    .SYNC_STAGES(SYNC_STAGES),
    .WIN_CYCLES (WIN_CYCLES),
    .MIN_TICKS  (MIN_TICKS)
  ) u_window (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_i),
    .gate_busy_i(gate_busy),
    .win_o      (win),
    .reload_o   (reload_int)
  );

  dial_burst_gate #(
    .STEP        (STEP),
    .DELAY_STAGES(DELAY_STAGES)
  ) u_gate (
    .clk   (clk),
    .rst   (rst),
    .win_i (win),
    .busy_o(gate_busy),
    .inc_o (inc_int)
  );

  dial_pos_mirror #(
    .POS_BITS(POS_BITS)
  ) u_mirror (
    .clk     (clk),
    .rst     (rst),
    .reload_i(reload_int),
    .inc_i   (inc_int),
    .pos_o   (pos_o)
  );

  assign inc_o    = inc_int;
  assign reload_o = reload_int;

endmodule

// File: rtl/dial_step_seq_chk.sv
module dial_step_seq_chk #(
  parameter int POS_BITS     = 10,
  parameter int DELAY_STAGES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                inc_o,
  input logic                reload_o,
  input logic [POS_BITS-1:0] pos_o
);
  localparam int SW = $clog2(DELAY_STAGES + 2);
  localparam logic [POS_BITS-1:0] POS_MAX = '1;

  // Cycles since the last reload, saturating at DELAY_STAGES
  logic [SW-1:0] since_rl;
  always_ff @(posedge clk) begin
    if (rst)                             since_rl <= SW'(DELAY_STAGES);
    else if (reload_o)                   since_rl <= '0;
    else if (since_rl != SW'(DELAY_STAGES)) since_rl <= since_rl + 1'b1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pos_o == '0 && !inc_o && !reload_o));

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    inc_o |=> !inc_o);

  a_r5_reload_single: assert property (@(posedge clk) disable iff (rst)
    reload_o |=> !reload_o);

  a_r5_reload_zero: assert property (@(posedge clk) disable iff (rst)
    reload_o |=> (pos_o == '0));

  a_r6_reload_first: assert property (@(posedge clk) disable iff (rst)
    inc_o |-> (since_rl == SW'(DELAY_STAGES)));

  a_r8_hold_at_top: assert property (@(posedge clk) disable iff (rst)
    (pos_o == POS_MAX && !reload_o) |=> (pos_o == POS_MAX));

  a_r9_pos_stable: assert property (@(posedge clk) disable iff (rst)
    (!reload_o && !inc_o) |=> $stable(pos_o));

  a_r9_pos_step: assert property (@(posedge clk) disable iff (rst)
    (!reload_o && inc_o && pos_o != POS_MAX) |=> (pos_o == $past(pos_o) + 1'b1));

endmodule

bind dial_step_seq dial_step_seq_chk #(
  .POS_BITS    (POS_BITS),
  .DELAY_STAGES(DELAY_STAGES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inc_o   (inc_o),
  .reload_o(reload_o),
  .pos_o   (pos_o)
);

// File: tb/dial_step_seq_test.sv
`timescale 1ns/1ps
module dial_step_seq_test;
  localparam int STEP_A = 17;
  localparam int STEP_B = 20;
  localparam int MINT   = 60;
  localparam int DLY    = 4;
  localparam int PMAX   = 1023;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic inc_a, rl_a, inc_b, rl_b;
  logic [9:0] pos_a, pos_b;

  always #2.5 clk = ~clk;

  dial_step_seq uut (
    .clk(clk), .rst(rst), .tick_i(tick),
    .inc_o(inc_a), .reload_o(rl_a), .pos_o(pos_a)
  );

  dial_step_seq #(.STEP(STEP_B)) uut_sat (
    .clk(clk), .rst(rst), .tick_i(tick),
    .inc_o(inc_b), .reload_o(rl_b), .pos_o(pos_b)
  );

  int checks = 0, fails = 0, cyc = 0;
  int pulses_a, pulses_b, b2b_a, rl_cnt_a, rl_cnt_b, rl_cyc_a, first_inc_a;
  bit prev_inc_a;
  int model_a = 0, model_b = 0, sec_m = 0, tick_cyc = 0;
  bit done = 0;
  bit hit_top = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (inc_a) begin
        pulses_a++;
        if (first_inc_a < 0) first_inc_a = cyc;
      end
      if (prev_inc_a && inc_a) b2b_a++;
      prev_inc_a = inc_a;
      if (inc_b) pulses_b++;
      if (rl_a) begin rl_cnt_a++; rl_cyc_a = cyc; end
      if (rl_b) rl_cnt_b++;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int next_pos(int p, int step, bit rl);
    int q = rl ? 0 : p;
    q = q + step;
    return (q > PMAX) ? PMAX : q;
  endfunction

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
  endtask

  // One accepted tick, optionally followed by an ignored one inside its window
  task automatic run_second(int gap, int extra);
    bit exp_rl;
    int used;
    @(posedge clk); #1;
    pulses_a = 0; pulses_b = 0; b2b_a = 0; rl_cnt_a = 0; rl_cnt_b = 0;
    rl_cyc_a = -1; first_inc_a = -1;
    @(negedge clk);
    tick_cyc = cyc;
    tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    used = 3;
    if (extra > 0) begin
      repeat (extra - 3) @(negedge clk);
      tick = 1'b1;
      repeat (3) @(negedge clk);
      tick = 1'b0;
      used = extra + 3;
    end
    repeat (gap - used) @(negedge clk);

    exp_rl = (sec_m == MINT - 1);
    sec_m  = exp_rl ? 0 : sec_m + 1;
    model_a = next_pos(model_a, STEP_A, exp_rl);
    model_b = next_pos(model_b, STEP_B, exp_rl);

    check(pulses_a == STEP_A, "R2", "strobes per tick", pulses_a, STEP_A);
    check(b2b_a == 0, "R2", "back-to-back strobes", b2b_a, 0);
    check(pulses_b == STEP_B, "R3", "counted burst, full window", pulses_b, STEP_B);
    check(first_inc_a - tick_cyc == 9, "R4", "first strobe latency", first_inc_a - tick_cyc, 9);
    check(rl_cnt_a == int'(exp_rl), "R5", "reload count", rl_cnt_a, int'(exp_rl));
    check(rl_cnt_b == int'(exp_rl), "R5", "reload count sat inst", rl_cnt_b, int'(exp_rl));
    if (exp_rl) begin
      check(rl_cyc_a - tick_cyc == 3, "R5", "reload latency", rl_cyc_a - tick_cyc, 3);
      check(first_inc_a - rl_cyc_a >= DLY, "R6", "reload to strobe gap", first_inc_a - rl_cyc_a, DLY);
    end
    if (extra > 0)
      check(pulses_a == STEP_A && rl_cnt_a == int'(exp_rl), "R7", "ignored tick strobes",
            pulses_a, STEP_A);
    check(int'(pos_a) == model_a, "R9", "position", int'(pos_a), model_a);
    check(int'(pos_b) == model_b, "R8", "saturating position", int'(pos_b), model_b);
    if (model_b == PMAX) hit_top = 1;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    check(pos_a == '0 && !inc_a && !rl_a, "R1", "reset outputs", int'(pos_a), 0);
    @(negedge clk) rst = 1'b0;
    repeat (3) @(negedge clk);
    check(pos_a == '0 && !inc_a && !rl_a, "R1", "after reset release", int'(pos_a), 0);

    void'($urandom(32'd4711));
    for (int i = 0; i < 125; i++) begin
      int gap = $urandom_range(60, 90);
      int extra = (i % 9 == 4 || i == 58) ? $urandom_range(8, 20) : 0;
      run_second(gap, extra);
    end
    check(hit_top, "R8", "saturation reached", int'(hit_top), 1);

    // Reset mid-minute returns the dial and seconds count to zero
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(pos_a == '0 && pos_b == '0, "R1", "mid-run reset position", int'(pos_a), 0);
    model_a = 0; model_b = 0; sec_m = 0;
    for (int i = 0; i < 3; i++) run_second(70, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule